// File: doc/BRIEF.md
# Host Status and Interrupt Register

This block is a 16-bit status and control word that a host reaches through a small I/O port (active-low chip select, read strobe and write strobe) at a single address. It gathers three event sources into sticky flags: a peripheral interrupt line, a tag parity error pulse and a data parity error pulse. It combines two of those groups into one host interrupt, each group with its own enable. The word also holds a handful of plain control bits (a general interrupt line, a hold-ignore control, a high-byte-select control) and a latched reset line for a local processor.

Some written bits are one-shot commands rather than storage. One clears the peripheral flag, one clears both parity flags, and two set or clear the local-processor reset latch. The memory sequencer and the parity checker outside this block only supply one-cycle event pulses. Every cycle in which the port is selected with a strobe low counts as one access.

Top module: `hsr_host_status`

## Requirements
- R1: A synchronous active-high `rst` clears every stored bit, flag and output. A read right after reset returns 0x0000, and all control outputs are low.
- R2: The stored control bits are 0x0001 (drives `hi_byte_sel`), 0x0002 (drives `gen_irq`), 0x0008 (drives `hold_ign`), 0x0080 (peripheral enable) and 0x0400 (parity enable). Every register write loads all five from the written word. Each output follows on the clock edge that takes the write, and the bits read back in place.
- R3: A write with 0x0800 set raises `lp_reset`. It stays high through later writes until a write with 0x1000 set. If both bits are in one write, the set wins. The latch state reads back at 0x0800.
- R4: The peripheral flag (read at 0x2000) is set on a low-to-high change of `per_irq_in`. It stays set after the input falls. An input held high after a clear does not set it again.
- R5: A write with 0x0200 set clears the peripheral flag. If a rising edge arrives in the same cycle, the flag stays set.
- R6: `tag_perr_evt` sets a flag read at 0x8000, and `data_perr_evt` sets a flag read at 0x4000. A write with 0x0100 set clears both. An event in the same cycle as the clear wins.
- R7: `host_irq` is (peripheral flag AND 0x0080 enable) OR ((either parity flag) AND 0x0400 enable). It changes on the same clock edge as the flag or enable that causes the change.
- R8: An access happens only when `io_cs_n` is low, a strobe is low and `io_addr` equals 0x5000. Writes anywhere else have no effect. `io_rdy` is high exactly during an addressed access. `io_rdata` is 0x0000 except during an addressed read.
- R9: The command bits (0x0100, 0x0200, 0x1000) and unused bits (0x0004, 0x0010, 0x0020) read as zero. Writing 1s to the flag positions 0x2000, 0x4000 and 0x8000 does not set the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_cs_n | input | 1 | Port chip select, active low |
| io_rd_n | input | 1 | Read strobe, active low |
| io_wr_n | input | 1 | Write strobe, active low |
| io_addr | input | 16 | Port address |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, zero when not read |
| io_rdy | output | 1 | High during an addressed access |
| per_irq_in | input | 1 | Peripheral interrupt request level |
| tag_perr_evt | input | 1 | Tag parity error pulse |
| data_perr_evt | input | 1 | Data parity error pulse |
| host_irq | output | 1 | Combined host interrupt |
| gen_irq | output | 1 | General interrupt line from control bit |
| lp_reset | output | 1 | Local-processor reset latch |
| hold_ign | output | 1 | Hold-ignore control |
| hi_byte_sel | output | 1 | High-byte-select control |

## Verification
A wrong flag or enable shows up at `host_irq` on the same clock edge. It also appears in the next read of the word, so a compare on every cycle catches it within one cycle of the stimulus that exposed it. Set-versus-clear collisions and input levels held high across a clear are driven on purpose. A wrong priority or a missing edge detect leaves a flag that a later read exposes. Writes to foreign addresses and to read-only positions are followed by a read, so that any state they disturbed becomes visible.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  // Bit positions in the status/control word (software decodes these)
  localparam int B_HBS    = 0;
  localparam int B_GIRQ   = 1;
  localparam int B_HOLD   = 3;
  localparam int B_PEN    = 7;
  localparam int B_CLRPAR = 8;
  localparam int B_CLRPER = 9;
  localparam int B_PAREN  = 10;
  localparam int B_RSTSET = 11;
  localparam int B_RSTCLR = 12;
  localparam int B_PERF   = 13;
  localparam int B_DATF   = 14;
  localparam int B_TAGF   = 15;

  // Sticky flag indices
  localparam int FL_TAG = 0;
  localparam int FL_DAT = 1;
  localparam int FL_PER = 2;
  localparam int NFLAG  = 3;
endpackage

// File: rtl/hsr_port_dec.sv
module hsr_port_dec #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h5000
) (
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              rdy
);
  logic sel;
  always_comb begin
    sel    = !cs_n && (addr == REG_ADDR);
    wr_hit = sel && !wr_n;
    rd_hit = sel && !rd_n;
    rdy    = wr_hit || rd_hit;
  end
endmodule

// File: rtl/hsr_sticky.sv
module hsr_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set has priority over clear
    always_comb begin
      if (set_ev[i])       flag_d[i] = 1'b1;
      else if (clr_cmd[i]) flag_d[i] = 1'b0;
      else                 flag_d[i] = flag_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/hsr_ctrl.sv
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctrl_d,
  output logic              lprst_q,
  output logic              lprst_d
);
  localparam logic [DATA_W-1:0] STORE_MASK =
    DATA_W'((1 << B_HBS) | (1 << B_GIRQ) | (1 << B_HOLD) |
            (1 << B_PEN) | (1 << B_PAREN));

  always_comb begin
    ctrl_d  = wr_hit ? (wdata & STORE_MASK) : ctrl_q;
    lprst_d = lprst_q;
    if (wr_hit) begin
      if (wdata[B_RSTSET])      lprst_d = 1'b1;
      else if (wdata[B_RSTCLR]) lprst_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      lprst_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      lprst_q <= lprst_d;
    end
  end
endmodule

// File: rtl/hsr_host_status.sv
module hsr_host_status
  import hsr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_cs_n,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rdy,
  input  logic              per_irq_in,
  input  logic              tag_perr_evt,
  input  logic              data_perr_evt,
  output logic              host_irq,
  output logic              gen_irq,
  output logic              lp_reset,
  output logic              hold_ign,
  output logic              hi_byte_sel
);
  logic wr_hit, rd_hit;

  hsr_port_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .cs_n(io_cs_n), .rd_n(io_rd_n), .wr_n(io_wr_n), .addr(io_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .rdy(io_rdy)
  );

  // previous level of the peripheral request, tracks the input even in reset
  logic per_prev_q;
  always_ff @(posedge clk) per_prev_q <= per_irq_in;

  logic [NFLAG-1:0] set_ev, clr_cmd, flag_q, flag_d;
  always_comb begin
    set_ev[FL_TAG]  = tag_perr_evt;
    set_ev[FL_DAT]  = data_perr_evt;
    set_ev[FL_PER]  = per_irq_in && !per_prev_q;
    clr_cmd[FL_TAG] = wr_hit && io_wdata[B_CLRPAR];
    clr_cmd[FL_DAT] = wr_hit && io_wdata[B_CLRPAR];
    clr_cmd[FL_PER] = wr_hit && io_wdata[B_CLRPER];
  end

  hsr_sticky #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_cmd(clr_cmd),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              lprst_q, lprst_d;

  hsr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(io_wdata),
    .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .lprst_q(lprst_q), .lprst_d(lprst_d)
  );

  // registered interrupt built from next-state values so it moves with them
  logic host_irq_q;
  always_ff @(posedge clk) begin
    if (rst) host_irq_q <= 1'b0;
    else     host_irq_q <= (flag_d[FL_PER] && ctrl_d[B_PEN]) ||
                           ((flag_d[FL_TAG] || flag_d[FL_DAT]) && ctrl_d[B_PAREN]);
  end

  logic [DATA_W-1:0] status_w;
  always_comb begin
    status_w           = ctrl_q;
    status_w[B_RSTSET] = lprst_q;
    status_w[B_PERF]   = flag_q[FL_PER];
    status_w[B_DATF]   = flag_q[FL_DAT];
    status_w[B_TAGF]   = flag_q[FL_TAG];
  end

  assign io_rdata    = rd_hit ? status_w : '0;
  assign host_irq    = host_irq_q;
  assign gen_irq     = ctrl_q[B_GIRQ];
  assign hold_ign    = ctrl_q[B_HOLD];
  assign hi_byte_sel = ctrl_q[B_HBS];
  assign lp_reset    = lprst_q;
endmodule

// File: rtl/hsr_host_status_chk.sv
module hsr_host_status_chk
  import hsr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h5000
) (
  input logic              clk,
  input logic              rst,
  input logic              io_cs_n,
  input logic              io_wr_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              per_irq_in,
  input logic              tag_perr_evt,
  input logic [NFLAG-1:0]  flag_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              host_irq,
  input logic              gen_irq,
  input logic              lp_reset
);
  logic wr;
  assign wr = !io_cs_n && !io_wr_n && (io_addr == REG_ADDR);

  AST_TAG_SET: assert property (@(posedge clk) disable iff (rst)
    tag_perr_evt |=> flag_q[FL_TAG]); // R6
  AST_PER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(per_irq_in) |=> flag_q[FL_PER]); // R4
  AST_PER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr && io_wdata[B_CLRPER] && !$rose(per_irq_in)) |=> !flag_q[FL_PER]); // R5
  AST_LP_SET: assert property (@(posedge clk) disable iff (rst)
    (wr && io_wdata[B_RSTSET]) |=> lp_reset); // R3
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lp_reset && !(wr && io_wdata[B_RSTCLR])) |=> lp_reset); // R3
  AST_HOST_IRQ: assert property (@(posedge clk) disable iff (rst)
    host_irq == ((flag_q[FL_PER] && ctrl_q[B_PEN]) ||
                 ((flag_q[FL_TAG] || flag_q[FL_DAT]) && ctrl_q[B_PAREN]))); // R7
  AST_GEN_IRQ: assert property (@(posedge clk) disable iff (rst)
    wr |=> (gen_irq == $past(io_wdata[B_GIRQ]))); // R2
endmodule

bind hsr_host_status hsr_host_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_cs_n(io_cs_n), .io_wr_n(io_wr_n),
  .io_addr(io_addr), .io_wdata(io_wdata), .per_irq_in(per_irq_in),
  .tag_perr_evt(tag_perr_evt), .flag_q(flag_q), .ctrl_q(ctrl_q),
  .host_irq(host_irq), .gen_irq(gen_irq), .lp_reset(lp_reset)
);

// File: tb/hsr_host_status_tb.sv
module hsr_host_status_tb_top;
  localparam int CLK_PER = 10;
  localparam logic [15:0] RA = 16'h5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic per_in = 1'b0, tagp = 1'b0, datp = 1'b0;
  logic [15:0] rdata;
  logic rdy, hirq, girq, lprst, hold, hbs;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  hsr_host_status dut_i (
    .clk(clk), .rst(rst), .io_cs_n(cs_n), .io_rd_n(rd_n), .io_wr_n(wr_n),
    .io_addr(addr), .io_wdata(wdata), .io_rdata(rdata), .io_rdy(rdy),
    .per_irq_in(per_in), .tag_perr_evt(tagp), .data_perr_evt(datp),
    .host_irq(hirq), .gen_irq(girq), .lp_reset(lprst),
    .hold_ign(hold), .hi_byte_sel(hbs)
  );

  // behavioural reference state
  bit m_tag, m_dat, m_per, m_prev, m_lp;
  bit m_hbs, m_gi, m_hold, m_pen, m_paren;

  always @(posedge clk) begin
    bit hit, rise;
    hit  = !cs_n && !wr_n && addr == RA;
    rise = per_in && !m_prev;
    if (rst) begin
      {m_tag, m_dat, m_per, m_lp, m_hbs, m_gi, m_hold, m_pen, m_paren} = '0;
    end else begin
      if (hit && wdata[8]) begin m_tag = 0; m_dat = 0; end
      if (hit && wdata[9]) m_per = 0;
      if (tagp) m_tag = 1;
      if (datp) m_dat = 1;
      if (rise) m_per = 1;
      if (hit) begin
        m_hbs = wdata[0]; m_gi = wdata[1]; m_hold = wdata[3];
        m_pen = wdata[7]; m_paren = wdata[10];
        if (wdata[12]) m_lp = 0;
        if (wdata[11]) m_lp = 1;
      end
    end
    m_prev = per_in;
  end

  function automatic logic [15:0] m_word();
    logic [15:0] w = '0;
    w[0] = m_hbs; w[1] = m_gi; w[3] = m_hold; w[7] = m_pen; w[10] = m_paren;
    w[11] = m_lp; w[13] = m_per; w[14] = m_dat; w[15] = m_tag;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    bit e_hirq, e_rdy;
    logic [15:0] e_rd;
    e_hirq = (m_per && m_pen) || ((m_tag || m_dat) && m_paren);
    e_rdy  = !cs_n && addr == RA && (!rd_n || !wr_n);
    e_rd   = (!cs_n && !rd_n && addr == RA) ? m_word() : 16'h0;
    chk(hirq === e_hirq, "R7", 16'(hirq), 16'(e_hirq));
    chk(lprst === m_lp, "R3", 16'(lprst), 16'(m_lp));
    chk({girq, hold, hbs} === {m_gi, m_hold, m_hbs}, "R2",
        16'({girq, hold, hbs}), 16'({m_gi, m_hold, m_hbs}));
    chk(rdy === e_rdy, "R8", 16'(rdy), 16'(e_rdy));
    chk(rdata === e_rd, "R9", rdata, e_rd);
  endtask

  // one bus cycle, then return the bus to idle
  task automatic bus(input bit c, input bit r, input bit w, input logic [15:0] a,
                     input logic [15:0] d, input bit tp, input bit dp);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d; tagp = tp; datp = dp;
    #(CLK_PER/4) cmp_all();
    @(negedge clk);
    cs_n = 1; rd_n = 1; wr_n = 1; tagp = 0; datp = 0;
    #(CLK_PER/4) cmp_all();
  endtask

  task automatic wr(input logic [15:0] d);
    bus(0, 1, 0, RA, d, 0, 0);
  endtask

  task automatic rd_exp(input logic [15:0] exp, input string req);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = RA;
    #(CLK_PER/4) cmp_all();
    chk(rdata === exp, req, rdata, exp);
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    #(CLK_PER/4) cmp_all();
  endtask

  task automatic set_per(input bit v);
    @(negedge clk);
    per_in = v;
    #(CLK_PER/4) cmp_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    #(CLK_PER/4) chk({hirq, girq, lprst, hold, hbs} === 5'b0, "R1", 16'({hirq, girq, lprst, hold, hbs}), 16'h0);
    rd_exp(16'h0000, "R1");
    // R2 stored control bits
    wr(16'h008B); rd_exp(16'h008B, "R2");
    chk(girq && hold && hbs, "R2", 16'({girq, hold, hbs}), 16'h7);
    wr(16'h0400); rd_exp(16'h0400, "R2");
    // R3 reset latch
    wr(16'h0800); rd_exp(16'h0800, "R3");
    wr(16'h0000); rd_exp(16'h0800, "R3");
    wr(16'h1000); rd_exp(16'h0000, "R3");
    wr(16'h1800); rd_exp(16'h0800, "R3");
    wr(16'h1000);
    // R4 peripheral flag capture, sticky
    wr(16'h0080);
    set_per(1); set_per(0);
    rd_exp(16'h2080, "R4");
    chk(hirq === 1'b1, "R7", 16'(hirq), 16'h1);
    // R5 clear, then level held high across clear
    wr(16'h0280); rd_exp(16'h0080, "R5");
    set_per(1);
    wr(16'h0280); rd_exp(16'h0080, "R4");
    set_per(0);
    // R5 collision: rising edge in clear cycle
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = RA; wdata = 16'h0280; per_in = 1;
    #(CLK_PER/4) cmp_all();
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    #(CLK_PER/4) cmp_all();
    rd_exp(16'h2080, "R5");
    set_per(0);
    wr(16'h0200);
    // R6 parity flags, R7 enable gating
    bus(1, 1, 1, RA, 16'h0, 1, 0);
    rd_exp(16'h8000, "R6");
    chk(hirq === 1'b0, "R7", 16'(hirq), 16'h0);
    wr(16'h0400); rd_exp(16'h8400, "R7");
    wr(16'h0000);
    chk(hirq === 1'b0, "R7", 16'(hirq), 16'h0);
    wr(16'h0100); rd_exp(16'h0000, "R6");
    bus(1, 1, 1, RA, 16'h0, 0, 1);
    rd_exp(16'h4000, "R6");
    bus(0, 1, 0, RA, 16'h0100, 1, 0);   // event wins over clear
    rd_exp(16'h8000, "R6");
    wr(16'h0100);
    // R8 decode: foreign address, no select, wrong read address
    bus(0, 1, 0, 16'h5002, 16'h08FF, 0, 0);
    bus(1, 1, 0, RA, 16'h08FF, 0, 0);
    rd_exp(16'h0000, "R8");
    bus(0, 0, 1, 16'h5004, 16'h0, 0, 0);
    chk(rdata === 16'h0 && rdy === 1'b0, "R8", rdata, 16'h0);
    // R9 read-only and command positions
    wr(16'hE034); rd_exp(16'h0000, "R9");
    repeat (4) begin @(negedge clk); #(CLK_PER/4) cmp_all(); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule